// File: doc/BRIEF.md
# Mixed-Page-Size Translation Buffer

This block is a small fully associative cache of address translations. It differs from a plain TLB in one way: each slot keeps its own match mask, so pages of several power-of-two sizes can sit in the same array. A lookup compares only the virtual address bits above a slot's page boundary. The bits below that boundary are the page offset, and they are copied unchanged into the physical address. The frame base supplies the upper bits.

Software loads slots through a fill port. The fill gives the virtual base, the physical base and the page size as log2 of the byte count, together with the user, writable and dirty attributes. The slot to load is picked by a round-robin pointer. A fill is refused if the size is outside the supported range or if either base has any offset bit set. Slots can be dropped one address at a time or all at once.

Lookups are registered and report hit, miss or protection fault one cycle later. Along with the outcome come:
- the translated address
- the slot's flags
- a multi-match warning
- a request to set the dirty bit when a write lands on a clean page

Top module: `vmask_tlb`

## Requirements
- R1: After reset every slot is invalid and every output is 0, so the first lookup of any address misses.
- R2: A fill is accepted only when MIN_OFF <= fill_size <= MAX_OFF and both bases are zero in their low fill_size bits. An accepted fill loads the slot at the round-robin pointer, marks it valid, clears its accessed flag and advances the pointer modulo ENTRIES. A refused fill raises fill_err in the next cycle, changes no slot and leaves the pointer where it was.
- R3: Lookup results appear in the cycle after lk_en, with lk_done high for one cycle. In that cycle exactly one of lk_hit, lk_miss and lk_fault is high.
- R4: A valid slot of size S matches when lk_va and its virtual base agree on every bit at position S or above. On a hit, lk_pa is the frame base OR the low S bits of lk_va.
- R5: Slots of different sizes are held together and each is matched with its own size.
- R6: When several slots match, the lowest-index slot supplies the result and lk_multi is high.
- R7: lk_flags is {dirty, accessed, writable, user}, taken from the winning slot as it stood before the lookup. A lookup that hits without a fault sets that slot's accessed flag.
- R8: A write hit on a slot whose dirty flag is 0 raises lk_dirty_req. Otherwise lk_dirty_req is 0. The dirty flag itself changes only on a fill.
- R9: A match with lk_write set on a non-writable slot, or with lk_user set on a supervisor slot (user flag 0), gives lk_fault. In that case lk_hit is 0, lk_pa is 0 and lk_dirty_req is 0, and lk_flags still shows the slot's flags.
- R10: inv_en clears every valid slot that matches inv_va under its own mask. inv_all clears every slot. If a fill arrives in the same cycle, the filled slot ends up valid.
- R11: On a miss, lk_pa, lk_flags, lk_multi and lk_dirty_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_en | input | 1 | Start a lookup |
| lk_va | input | VA_W | Lookup virtual address |
| lk_write | input | 1 | Lookup is a write |
| lk_user | input | 1 | Lookup comes from user mode |
| fill_en | input | 1 | Load a slot |
| fill_va | input | VA_W | Virtual page base |
| fill_pa | input | PA_W | Physical frame base |
| fill_size | input | $clog2(VA_W+1) | log2 of page size in bytes |
| fill_user | input | 1 | Page open to user mode |
| fill_writable | input | 1 | Page writable |
| fill_dirty | input | 1 | Initial dirty flag |
| inv_en | input | 1 | Invalidate slots matching inv_va |
| inv_va | input | VA_W | Address to invalidate |
| inv_all | input | 1 | Invalidate every slot |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | No slot matched |
| lk_fault | output | 1 | Permission violation |
| lk_multi | output | 1 | More than one slot matched |
| lk_dirty_req | output | 1 | Write hit on clean page |
| lk_pa | output | PA_W | Translated physical address |
| lk_flags | output | 4 | {dirty, accessed, writable, user} of winning slot |
| fill_err | output | 1 | Previous fill refused |

## Verification
A corrupted slot mask or base shows up at the ports in the next cycle. The lookup result is registered once, so any address inside or just beside the affected page returns a wrong lk_pa, or a hit where a miss is due, or the reverse. A misplaced round-robin pointer or a stale valid bit stays hidden until a later fill or invalidate lands on the wrong slot. After that, the next sweep of lookups across the address space shows the difference. A lost accessed-flag update is seen in lk_flags on the second lookup of the same page.

// File: rtl/vmask_tlb.sv
module vmask_tlb #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int MIN_OFF = 12,
  parameter int MAX_OFF = 30,
  parameter int ENTRIES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       lk_en,
  input  logic [VA_W-1:0]            lk_va,
  input  logic                       lk_write,
  input  logic                       lk_user,
  input  logic                       fill_en,
  input  logic [VA_W-1:0]            fill_va,
  input  logic [PA_W-1:0]            fill_pa,
  input  logic [$clog2(VA_W+1)-1:0]  fill_size,
  input  logic                       fill_user,
  input  logic                       fill_writable,
  input  logic                       fill_dirty,
  input  logic                       inv_en,
  input  logic [VA_W-1:0]            inv_va,
  input  logic                       inv_all,
  output logic                       lk_done,
  output logic                       lk_hit,
  output logic                       lk_miss,
  output logic                       lk_fault,
  output logic                       lk_multi,
  output logic                       lk_dirty_req,
  output logic [PA_W-1:0]            lk_pa,
  output logic [3:0]                 lk_flags,
  output logic                       fill_err
);
  localparam int SZ_W  = $clog2(VA_W+1);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [VA_W-1:0] OFF_LIM = {VA_W{1'b1}} >> (VA_W - MAX_OFF);

  logic [VA_W-1:0] e_va   [ENTRIES];
  logic [VA_W-1:0] e_mask [ENTRIES];
  logic [PA_W-1:0] e_pa   [ENTRIES];
  logic [ENTRIES-1:0] e_v, e_a, e_u, e_w, e_d;
  logic [IDX_W-1:0] ptr;

  logic [ENTRIES-1:0] lk_match, inv_match;
  logic [IDX_W-1:0]   win;
  logic               found, multi_c, fault_c;
  logic [PA_W-1:0]    pa_c;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign lk_match[i]  = e_v[i] && (((lk_va  ^ e_va[i]) & e_mask[i]) == '0);
    assign inv_match[i] = e_v[i] && (((inv_va ^ e_va[i]) & e_mask[i]) == '0);
  end

  always_comb begin
    win = '0;
    for (int i = ENTRIES-1; i >= 0; i--)
      if (lk_match[i]) win = IDX_W'(i);
  end

  assign found   = |lk_match;
  assign multi_c = (lk_match & (lk_match - 1'b1)) != '0;
  assign fault_c = found && ((lk_write && !e_w[win]) || (lk_user && !e_u[win]));
  assign pa_c    = e_pa[win] | PA_W'(lk_va & ~e_mask[win] & OFF_LIM);

  logic [VA_W-1:0] fmask;
  logic            fill_ok;
  assign fmask   = {VA_W{1'b1}} << fill_size;
  assign fill_ok = (fill_size >= SZ_W'(MIN_OFF)) && (fill_size <= SZ_W'(MAX_OFF))
                && ((fill_va & ~fmask) == '0)
                && ((fill_pa & PA_W'(~fmask & OFF_LIM)) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_v <= '0;
      e_a <= '0;
      ptr <= '0;
    end else begin
      if (lk_en && found && !fault_c) e_a[win] <= 1'b1;
      if (inv_all)     e_v <= '0;
      else if (inv_en) e_v <= e_v & ~inv_match;
      if (fill_en && fill_ok) begin
        e_v[ptr] <= 1'b1;
        e_a[ptr] <= 1'b0;
        ptr <= (ptr == IDX_W'(ENTRIES-1)) ? '0 : ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && fill_ok) begin
      e_va[ptr]   <= fill_va;
      e_mask[ptr] <= fmask;
      e_pa[ptr]   <= fill_pa;
      e_u[ptr]    <= fill_user;
      e_w[ptr]    <= fill_writable;
      e_d[ptr]    <= fill_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_done <= 1'b0; lk_hit <= 1'b0; lk_miss <= 1'b0; lk_fault <= 1'b0;
      lk_multi <= 1'b0; lk_dirty_req <= 1'b0; lk_pa <= '0; lk_flags <= '0;
      fill_err <= 1'b0;
    end else begin
      fill_err     <= fill_en && !fill_ok;
      lk_done      <= lk_en;
      lk_hit       <= lk_en && found && !fault_c;
      lk_miss      <= lk_en && !found;
      lk_fault     <= lk_en && fault_c;
      lk_multi     <= lk_en && multi_c;
      lk_dirty_req <= lk_en && found && !fault_c && lk_write && !e_d[win];
      lk_pa        <= (lk_en && found && !fault_c) ? pa_c : '0;
      lk_flags     <= (lk_en && found) ? {e_d[win], e_a[win], e_w[win], e_u[win]} : 4'b0;
    end
  end

  assert_one_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_done |-> $countones({lk_hit, lk_miss, lk_fault}) == 1);
  assert_done_follows_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_done |-> $past(lk_en));
  assert_offset_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_pa[MIN_OFF-1:0] == $past(lk_va[MIN_OFF-1:0]));
  assert_dirty_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_dirty_req |-> lk_hit && $past(lk_write) && !lk_flags[3]);
  assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_pa == '0 && !lk_dirty_req && !lk_hit);
  assert_miss_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> lk_pa == '0 && lk_flags == 4'b0 && !lk_multi && !lk_dirty_req);
  assert_refused_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_err |-> $past(fill_en) && ptr == $past(ptr));
  assert_multi_needs_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> lk_hit || lk_fault);
endmodule

// File: tb/tb_vmask_tlb.sv
`timescale 1ns/1ps
module tb_vmask_tlb;
  localparam int VA_W = 16, PA_W = 16, MIN_OFF = 4, MAX_OFF = 12, ENTRIES = 4;
  localparam int SZ_W = $clog2(VA_W+1);

  logic clk = 0, rst_n = 0;
  logic lk_en = 0, lk_write = 0, lk_user = 0;
  logic [VA_W-1:0] lk_va = '0, fill_va = '0, inv_va = '0;
  logic [PA_W-1:0] fill_pa = '0;
  logic [SZ_W-1:0] fill_size = '0;
  logic fill_en = 0, fill_user = 0, fill_writable = 0, fill_dirty = 0;
  logic inv_en = 0, inv_all = 0;
  logic lk_done, lk_hit, lk_miss, lk_fault, lk_multi, lk_dirty_req, fill_err;
  logic [PA_W-1:0] lk_pa;
  logic [3:0] lk_flags;

  always #2 clk = ~clk;

  vmask_tlb #(.VA_W(VA_W), .PA_W(PA_W), .MIN_OFF(MIN_OFF), .MAX_OFF(MAX_OFF), .ENTRIES(ENTRIES)) dut (
    .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_va(lk_va), .lk_write(lk_write), .lk_user(lk_user),
    .fill_en(fill_en), .fill_va(fill_va), .fill_pa(fill_pa), .fill_size(fill_size),
    .fill_user(fill_user), .fill_writable(fill_writable), .fill_dirty(fill_dirty),
    .inv_en(inv_en), .inv_va(inv_va), .inv_all(inv_all),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
    .lk_multi(lk_multi), .lk_dirty_req(lk_dirty_req), .lk_pa(lk_pa), .lk_flags(lk_flags),
    .fill_err(fill_err));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic          mv [ENTRIES];
  logic [15:0]   mva [ENTRIES], mpa [ENTRIES];
  int            msz [ENTRIES];
  logic          mu [ENTRIES], mw [ENTRIES], md [ENTRIES], ma [ENTRIES];
  int            mptr = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic lookup(input logic [15:0] va, input logic wr, input logic us, input string ctag);
    int nm, win;
    logic [25:0] exp, got;
    logic eh, em, ef, edr;
    logic [15:0] epa;
    logic [3:0] efl;
    string rtag;
    @(negedge clk);
    lk_en = 1; lk_va = va; lk_write = wr; lk_user = us;
    nm = 0; win = 0;
    for (int i = ENTRIES-1; i >= 0; i--)
      if (mv[i] && (((va ^ mva[i]) >> msz[i]) == 0)) begin nm++; win = i; end
    em = (nm == 0);
    ef = !em && ((wr && !mw[win]) || (us && !mu[win]));
    eh = !em && !ef;
    edr = eh && wr && !md[win];
    epa = eh ? (mpa[win] | (va & 16'((1 << msz[win]) - 1))) : 16'h0;
    efl = em ? 4'b0 : {md[win], ma[win], mw[win], mu[win]};
    exp = {1'b1, eh, em, ef, (nm > 1), edr, epa, efl};
    if (em) rtag = "R11"; else if (ef) rtag = "R9"; else if (nm > 1) rtag = "R6";
    else if (edr) rtag = "R8"; else rtag = "R4";
    @(negedge clk);
    got = {lk_done, lk_hit, lk_miss, lk_fault, lk_multi, lk_dirty_req, lk_pa, lk_flags};
    lk_en = 0;
    check(got == exp, {ctag, "/", rtag, "/R3"}, 32'(got), 32'(exp));
    if (eh) ma[win] = 1'b1;
  endtask

  task automatic op(input logic fen, input logic [15:0] va, input logic [15:0] pa, input int sz,
                    input logic u, input logic w, input logic d,
                    input logic ien, input logic [15:0] iva, input logic iall, input string ctag);
    logic ok;
    @(negedge clk);
    fill_en = fen; fill_va = va; fill_pa = pa; fill_size = SZ_W'(sz);
    fill_user = u; fill_writable = w; fill_dirty = d;
    inv_en = ien; inv_va = iva; inv_all = iall;
    ok = (sz >= MIN_OFF) && (sz <= MAX_OFF) &&
         ((va & 16'((1 << sz) - 1)) == 0) && ((pa & 16'((1 << sz) - 1)) == 0);
    @(negedge clk);
    fill_en = 0; inv_en = 0; inv_all = 0;
    if (fen) check(fill_err == !ok, {ctag, "/R2"}, 32'(fill_err), 32'(!ok));
    if (iall) for (int i = 0; i < ENTRIES; i++) mv[i] = 0;
    else if (ien)
      for (int i = 0; i < ENTRIES; i++)
        if (mv[i] && (((iva ^ mva[i]) >> msz[i]) == 0)) mv[i] = 0;
    if (fen && ok) begin
      mv[mptr] = 1; mva[mptr] = va; mpa[mptr] = pa; msz[mptr] = sz;
      mu[mptr] = u; mw[mptr] = w; md[mptr] = d; ma[mptr] = 0;
      mptr = (mptr + 1) % ENTRIES;
    end
  endtask

  task automatic sweep(input int step, input string ctag);
    int k = 0;
    for (int a = 0; a < 65536; a += step) begin
      lookup(16'(a), k[0], k[1], ctag);
      k++;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin mv[i] = 0; ma[i] = 0; msz[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state of outputs
    check({lk_done, lk_hit, lk_miss, lk_fault, lk_multi, lk_dirty_req, lk_pa, lk_flags, fill_err} == '0,
          "R1", 32'({lk_done, lk_hit, lk_miss, lk_fault, lk_pa}), 32'h0);
    lookup(16'h0000, 0, 0, "R1");
    lookup(16'h8123, 1, 1, "R1");
    sweep(509, "R1");

    // R5: four slots of mixed sizes
    op(1, 16'h1230, 16'hA450, 4,  1, 1, 0, 0, 0, 0, "R5");
    op(1, 16'h4500, 16'h7700, 8,  1, 0, 0, 0, 0, 0, "R5");
    op(1, 16'h8000, 16'h3000, 12, 0, 1, 1, 0, 0, 0, "R5");
    op(1, 16'h2040, 16'h9FC0, 6,  1, 1, 1, 0, 0, 0, "R5");
    // R7: accessed flag observed before and after first hit
    lookup(16'h1234, 0, 1, "R7");
    lookup(16'h1234, 0, 1, "R7");
    // R8: clean writable page, write hit
    lookup(16'h123F, 1, 0, "R8");
    // R9: write to read-only, user to supervisor
    lookup(16'h45AB, 1, 0, "R9");
    lookup(16'h8FFF, 0, 1, "R9");
    // R4: page boundaries
    lookup(16'h122F, 0, 0, "R4");
    lookup(16'h1240, 0, 0, "R4");
    lookup(16'h207F, 0, 0, "R4");
    lookup(16'h2080, 0, 0, "R4");
    sweep(23, "R5");

    // R2: refused fills
    op(1, 16'h5000, 16'h6000, 3,  1, 1, 0, 0, 0, 0, "R2 size low");
    op(1, 16'h0000, 16'h0000, 13, 1, 1, 0, 0, 0, 0, "R2 size high");
    op(1, 16'h5008, 16'h6000, 4,  1, 1, 0, 0, 0, 0, "R2 va align");
    op(1, 16'h5000, 16'h0108, 8,  1, 1, 0, 0, 0, 0, "R2 pa align");
    sweep(29, "R2");

    // R6: overlapping slots, lowest index wins
    op(1, 16'h8200, 16'h1100, 8, 1, 1, 0, 0, 0, 0, "R6");
    op(1, 16'h8240, 16'h5540, 6, 1, 0, 1, 0, 0, 0, "R6");
    lookup(16'h8250, 0, 1, "R6");
    lookup(16'h8250, 1, 0, "R6");
    lookup(16'h8310, 0, 0, "R6");
    sweep(31, "R6");

    // R10: single-address invalidate hits every matching slot
    op(0, 0, 0, 4, 0, 0, 0, 1, 16'h8250, 0, "R10");
    lookup(16'h8250, 0, 0, "R10");
    lookup(16'h2041, 0, 0, "R10");
    // R10: fill and invalidate in one cycle
    op(1, 16'h1230, 16'hB000, 4, 1, 1, 1, 1, 16'h2050, 0, "R10");
    lookup(16'h1237, 1, 1, "R10");
    lookup(16'h2050, 0, 0, "R10");
    sweep(37, "R10");
    // R10: fill together with clear-all keeps the new slot
    op(1, 16'hC000, 16'h4000, 10, 1, 1, 0, 0, 0, 1, "R10");
    lookup(16'hC3FF, 0, 0, "R10");
    op(0, 0, 0, 4, 0, 0, 0, 0, 0, 1, "R10");
    sweep(41, "R10");

    summary();
  end
endmodule